// File: doc/BRIEF.md
# Flash Command Decoder

This block sits on the device side of a parallel NOR-style flash array that is written sixteen bits at a time. Every bus write is read as a command byte or as the second cycle of a command. The commands arm a program, start a sector erase, set or clear a sector's lock bit, pick what bus reads return, and clear the error flags. A small register array stands in for the cells.

Program and erase start a busy counter. While it runs, the ready flag is low. The decoder keeps one lock bit per sector and a status byte with a ready flag and three error flags. Bus reads are combinational and return one of three views, chosen by the last command that selected a view: array data, the status byte, or the lock word.

The address is a halfword index. With the defaults there are twelve sectors of four halfwords each. Sectors 0 to 7 stand for the large main sectors and sectors 8 to 11 for the small secondary ones.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset, every halfword reads 0xFFFF and all twelve sectors are locked. The status byte is 0x80 and reads return array data.
- R2: Writing command 0x40 arms a program. The next write ANDs its 16-bit data into the addressed halfword. If that halfword's sector is locked, the array is left unchanged and status bits 4 and 1 are set instead.
- R3: Writing 0x20 and then 0xD0 to any address in a sector sets every halfword of that sector to 0xFFFF. If the sector is locked, status bits 5 and 1 are set instead. A second byte other than 0xD0 cancels the erase and selects array reads.
- R4: Writing 0x60 and then 0x01 locks the addressed sector, and 0x60 then 0xD0 unlocks it. Any other second byte leaves the lock bits alone and selects array reads.
- R5: Writing 0x70 selects status reads. Reads then return {8'h00, status}, and status bit 7 is 1 when the device is ready.
- R6: An accepted program or erase holds status bit 7 at 0 for exactly BUSY_CYC cycles (default 8). During that time every write is ignored except 0x70.
- R7: Writing 0x50 clears status bits 5, 4 and 1 and does not change the read view.
- R8: Writing 0x90 selects lock reads. Reads then return a word in which bit i is the lock bit of sector i, and bits 15 to 12 read 0.
- R9: Writing 0xFF selects array reads. Any command byte the decoder does not recognise also selects array reads and leaves the status byte unchanged.
- R10: The sector of an address is addr / 4. Sectors at index 12 and above are treated as locked: program and erase there fail with status bit 1, and lock commands there have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| addr | input | 6 | Halfword address |
| wdata | input | 16 | Write data; the low byte is the command byte |
| rdata | output | 16 | Read data for the current read view |

## Verification
The busy counter running out and a new command arriving can fall on the same clock edge. The bench starts a program and then places a lock-read command exactly on the last busy cycle, BUSY_CYC edges after the start. That command must be dropped, so reads still show the status byte with bit 7 now set. The same command is then sent one cycle later and must switch the view to the lock word.

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm #(
  parameter int NSECT    = 12,
  parameter int WPS      = 4,
  parameter int BUSY_CYC = 8,
  localparam int SECT_W  = $clog2(NSECT),
  localparam int WPS_W   = $clog2(WPS),
  localparam int ADDR_W  = SECT_W + WPS_W,
  localparam int NWORD   = NSECT * WPS,
  localparam int CNT_W   = $clog2(BUSY_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata
);
  localparam logic [1:0] M_ARR = 2'd0, M_STS = 2'd1, M_LCK = 2'd2;
  localparam logic [1:0] P_NONE = 2'd0, P_PGM = 2'd1, P_ERS = 2'd2, P_LCK = 2'd3;

  logic [15:0]      mem_q [NWORD];
  logic [NSECT-1:0] lock_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       mode_q, pend_q;
  logic             e_ers, e_pgm, e_lck;
  logic             sec_lck;

  wire [7:0]        cmd   = wdata[7:0];
  wire [SECT_W-1:0] sect  = addr[ADDR_W-1:WPS_W];
  wire              in_rng = int'(sect) < NSECT;
  wire              ready = (cnt_q == '0);
  wire [7:0]        stat  = {ready, 1'b0, e_ers, e_pgm, 2'b00, e_lck, 1'b0};

  always_comb begin
    sec_lck = 1'b1;
    for (int i = 0; i < NSECT; i++)
      if (int'(sect) == i) sec_lck = lock_q[i];
  end

  always_comb begin
    case (mode_q)
      M_STS:   rdata = {8'h00, stat};
      M_LCK:   rdata = 16'(lock_q);
      default: rdata = in_rng ? mem_q[addr] : 16'hFFFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORD; i++) mem_q[i] <= 16'hFFFF;
      lock_q <= '1;
      cnt_q  <= '0;
      mode_q <= M_ARR;
      pend_q <= P_NONE;
      e_ers  <= 1'b0;
      e_pgm  <= 1'b0;
      e_lck  <= 1'b0;
    end else begin
      if (!ready) cnt_q <= cnt_q - 1'b1;
      if (wr_en) begin
        if (!ready) begin
          if (cmd == 8'h70) mode_q <= M_STS;
        end else begin
          case (pend_q)
            P_PGM: begin
              pend_q <= P_NONE;
              if (sec_lck) begin
                e_pgm <= 1'b1;
                e_lck <= 1'b1;
              end else begin
                mem_q[addr] <= mem_q[addr] & wdata;
                cnt_q <= CNT_W'(BUSY_CYC);
              end
            end
            P_ERS: begin
              pend_q <= P_NONE;
              if (cmd != 8'hD0) mode_q <= M_ARR;
              else if (sec_lck) begin
                e_ers <= 1'b1;
                e_lck <= 1'b1;
              end else begin
                for (int i = 0; i < NWORD; i++)
                  if (i / WPS == int'(sect)) mem_q[i] <= 16'hFFFF;
                cnt_q <= CNT_W'(BUSY_CYC);
              end
            end
            P_LCK: begin
              pend_q <= P_NONE;
              if (cmd == 8'h01 || cmd == 8'hD0) begin
                for (int i = 0; i < NSECT; i++)
                  if (int'(sect) == i) lock_q[i] <= (cmd == 8'h01);
              end else mode_q <= M_ARR;
            end
            default: begin
              case (cmd)
                8'h40: pend_q <= P_PGM;
                8'h20: pend_q <= P_ERS;
                8'h60: pend_q <= P_LCK;
                8'h70: mode_q <= M_STS;
                8'h90: mode_q <= M_LCK;
                8'h50: begin
                  e_ers <= 1'b0;
                  e_pgm <= 1'b0;
                  e_lck <= 1'b0;
                end
                default: mode_q <= M_ARR;
              endcase
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/flash_cmd_fsm_chk.sv
module flash_cmd_fsm_chk #(
  parameter int NSECT = 12,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [15:0]      wdata,
  input logic [CNT_W-1:0] cnt_q,
  input logic [1:0]       pend_q,
  input logic [1:0]       mode_q,
  input logic [NSECT-1:0] lock_q,
  input logic [7:0]       stat,
  input logic             sec_lck
);
  wire idle_wr = wr_en && cnt_q == '0;
  wire known = wdata[7:0] inside {8'h40, 8'h20, 8'h60, 8'h70, 8'h50, 8'hFF, 8'h90};

  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cnt_q != '0 && wdata[7:0] != 8'h70)
      |=> ($stable(lock_q) && $stable(mode_q) && $stable(stat[5:1])));

  // R2
  pgm_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_wr && pend_q == 2'd1 && sec_lck) |=> (stat[7] && stat[4] && stat[1]));

  // R3
  ers_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_wr && pend_q == 2'd2 && wdata[7:0] == 8'hD0 && !sec_lck) |=> !stat[7]);

  // R7
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_wr && pend_q == 2'd0 && wdata[7:0] == 8'h50) |=> ((stat & 8'h32) == 8'h00));

  // R9
  unknown_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_wr && pend_q == 2'd0 && !known) |=> (mode_q == 2'd0 && $stable(stat)));
endmodule

bind flash_cmd_fsm flash_cmd_fsm_chk #(.NSECT(NSECT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .cnt_q(cnt_q),
  .pend_q(pend_q), .mode_q(mode_q), .lock_q(lock_q), .stat(stat), .sec_lck(sec_lck)
);

// File: tb/flash_cmd_fsm_test.sv
module flash_cmd_fsm_test;
  localparam int BUSY = 8;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [5:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  int n_chk = 0, n_bad = 0;

  flash_cmd_fsm #(.BUSY_CYC(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata));

  always #5 clk = ~clk;

  task automatic wr(input int a, input logic [15:0] d);
    wr_en = 1'b1; addr = 6'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int a, input logic [15:0] exp);
    addr = 6'(a); #1;
    n_chk++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: rdata=%h expected=%h", req, rdata, exp);
    end
  endtask

  task automatic t_reset;
    chk("R1 array", 0, 16'hFFFF);
    chk("R1 array", 47, 16'hFFFF);
    wr(0, 16'h0070); chk("R1 R5 status", 0, 16'h0080);
    wr(0, 16'h0090); chk("R1 R8 locks", 0, 16'h0FFF);
    wr(0, 16'h00FF); chk("R9 array view", 3, 16'hFFFF);
  endtask

  task automatic t_pgm_locked;
    wr(0, 16'h0040); wr(5, 16'h1234);
    wr(0, 16'h0070); chk("R2 locked program status", 0, 16'h0092);
    wr(0, 16'h0050); chk("R7 clear keeps status view", 0, 16'h0080);
    wr(0, 16'h00FF); chk("R2 locked data kept", 5, 16'hFFFF);
  endtask

  task automatic t_unlock;
    wr(4, 16'h0060); wr(4, 16'h00D0);
    wr(0, 16'h0060); wr(0, 16'h00D0);
    wr(0, 16'h0090); chk("R4 R8 unlock", 0, 16'h0FFC);
    wr(0, 16'h0060); wr(0, 16'h0042);
    chk("R4 cancel selects array", 0, 16'hFFFF);
    wr(0, 16'h0090); chk("R4 cancel keeps locks", 0, 16'h0FFC);
  endtask

  task automatic t_program;
    wr(0, 16'h0040); wr(5, 16'h1234); idle(BUSY);
    wr(0, 16'h00FF); chk("R2 program", 5, 16'h1234);
    wr(0, 16'h0040); wr(5, 16'hFF0F); idle(BUSY);
    chk("R2 AND", 5, 16'h1204);
    wr(0, 16'h0040); wr(3, 16'h0000); idle(BUSY);
    wr(0, 16'h0040); wr(4, 16'h5555); idle(BUSY);
    chk("R10 sector 0 word", 3, 16'h0000);
  endtask

  task automatic t_busy_edge;
    wr(0, 16'h0070);
    wr(0, 16'h0040); wr(6, 16'hAAAA);
    chk("R6 busy low", 0, 16'h0000);
    idle(BUSY - 1);
    chk("R6 still busy", 0, 16'h0000);
    wr(0, 16'h0090);
    chk("R6 dropped on last busy cycle", 0, 16'h0080);
    wr(0, 16'h0090);
    chk("R6 R8 accepted after busy", 0, 16'h0FFC);
    wr(0, 16'h00FF); chk("R2 busy write data", 6, 16'hAAAA);
  endtask

  task automatic t_erase;
    wr(0, 16'h0020); wr(0, 16'h0070);
    chk("R3 cancel selects array", 3, 16'h0000);
    wr(7, 16'h0020); wr(7, 16'h00D0);
    wr(0, 16'h0070); chk("R3 erase busy", 0, 16'h0000);
    idle(BUSY);
    wr(0, 16'h00FF);
    chk("R3 erased", 4, 16'hFFFF);
    chk("R3 erased", 5, 16'hFFFF);
    chk("R3 erased", 6, 16'hFFFF);
    chk("R3 other sector kept", 3, 16'h0000);
    wr(12, 16'h0020); wr(12, 16'h00D0);
    wr(0, 16'h0070); chk("R3 locked erase status", 0, 16'h00A2);
    wr(0, 16'h0050); chk("R7 clear", 0, 16'h0080);
  endtask

  task automatic t_range;
    wr(48, 16'h0060); wr(48, 16'h00D0);
    wr(0, 16'h0090); chk("R10 out of range unlock", 0, 16'h0FFC);
    wr(0, 16'h0040); wr(50, 16'h0000);
    wr(0, 16'h0070); chk("R10 out of range program", 0, 16'h0092);
    wr(0, 16'h00FF); chk("R10 read out of range", 50, 16'hFFFF);
  endtask

  task automatic t_unknown;
    wr(0, 16'h0070);
    wr(0, 16'h0033); chk("R9 unknown selects array", 3, 16'h0000);
    wr(0, 16'h0070); chk("R9 status kept", 0, 16'h0092);
    wr(0, 16'h0050); chk("R7 clear", 0, 16'h0080);
  endtask

  task automatic t_lock;
    wr(1, 16'h0060); wr(1, 16'h0001);
    wr(0, 16'h0090); chk("R4 lock", 0, 16'h0FFD);
    wr(0, 16'h0040); wr(2, 16'h0000);
    wr(0, 16'h0070); chk("R2 relocked sector", 0, 16'h0092);
    wr(0, 16'h0050);
    wr(0, 16'h00FF); chk("R2 relocked data", 2, 16'hFFFF);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    t_reset();
    t_pgm_locked();
    t_unlock();
    t_program();
    t_busy_edge();
    t_erase();
    t_range();
    t_unknown();
    t_lock();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule